// File: doc/BRIEF.md
# Shift-Register Clock Divider

This block divides a free-running input clock by a fixed even ratio, 25000 by default. It counts with a 14-bit maximal-length shift register that uses inverted-parity feedback, not with a binary counter. The register starts from a chosen start state and steps once per input clock. When it reaches a terminal state it loads the start state again, and on that same edge the divided output flips. The spacing between flips is therefore set by where the terminal state lies in the register's sequence, not by its numeric value.

The terminal state is a parameter. By default it is derived at elaboration from the start state and the wanted half-period, so the number of steps from start to terminal always matches the ratio. A synchronous reset loads the start state and clears the output. After reset is released the output begins low.

Top module: `lfsr_clk_div`

## Requirements
- R1: The counting register is 14 bits wide. Each step shifts it one place toward the MSB, and the new bit 0 is the inverse of the XOR of bits 13, 4, 2 and 0. From any legal state this gives a sequence of 16383 distinct states.
- R2: The register never holds the all-ones state. The start state is never all-ones.
- R3: By default the terminal state is the state reached HALF_PERIOD-1 steps after the start state. HALF_PERIOD defaults to 12500.
- R4: A synchronous reset loads the start state into the register, so counting restarts from the beginning.
- R5: While reset is asserted, and on the first cycle after it is released, the output is 0.
- R6: On the edge where the register holds the terminal state, the register loads the start state instead of stepping, and the output inverts on that same edge.
- R7: Outside reset the output stays high for exactly HALF_PERIOD input cycles and low for exactly HALF_PERIOD input cycles, so the output period is 2*HALF_PERIOD cycles.
- R8: The first rising edge of the output comes on the HALF_PERIOD-th input rising edge after reset is released.
- R9: A reset applied in the middle of a half-period, including while the output is high, clears the output. The next rise again comes exactly HALF_PERIOD cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| srst | input | 1 | Synchronous reset, active high |
| clk_div_out | output | 1 | Divided square wave, low after reset |

## Verification
The hardest case to reach is a reset that lands on the very cycle the register holds the terminal state, when a flip is due on the same edge. Reaching it from the ports means counting cycles exactly from the last release. The bench does this on a second, short-ratio instance: it releases reset, waits exactly HALF_PERIOD-1 cycles and asserts reset again. It also throws many resets at random instants, some of them while the output is high. The long default ratio is checked by measuring whole high and low spans, and the feedback taps are checked by giving the short instance a terminal state that the bench computes with its own model.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  typedef logic [31:0] lfsr_word_t;

  // One step of an inverted-parity shift register of the given width.
  function automatic lfsr_word_t lfsr_step(input lfsr_word_t s,
                                           input lfsr_word_t taps,
                                           input int width);
    lfsr_word_t mask;
    logic       fb;
    mask = (width >= 32) ? '1 : ((32'd1 << width) - 32'd1);
    fb   = ~(^(s & taps));
    return ((s << 1) | {31'd0, fb}) & mask;
  endfunction

  // Advance by n steps. The loops are nested so that no single loop runs long.
  function automatic lfsr_word_t lfsr_advance(input lfsr_word_t s,
                                              input lfsr_word_t taps,
                                              input int width,
                                              input int n);
    lfsr_word_t v;
    int blocks;
    int rest;
    v      = s;
    blocks = n / 100;
    rest   = n % 100;
    for (int b = 0; b < blocks; b++) begin
      for (int i = 0; i < 100; i++) begin
        v = lfsr_step(v, taps, width);
      end
    end
    for (int j = 0; j < rest; j++) begin
      v = lfsr_step(v, taps, width);
    end
    return v;
  endfunction

endpackage

// File: rtl/lfsr_div_core.sv
module lfsr_div_core #(
  parameter int             W     = 14,
  parameter logic [W-1:0]   TAPS  = 14'h2015,
  parameter logic [W-1:0]   START = '0,
  parameter logic [W-1:0]   TERM  = '0
) (
  input  logic clk,
  input  logic srst,
  output logic at_term
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_step;
  logic         fb;

  // Inverse of the plain parity of the taps; excludes the all-ones state.
  assign fb         = ~(^(state_q & TAPS));
  assign state_step = {state_q[W-2:0], fb};
  assign at_term    = (state_q == TERM);

  always_ff @(posedge clk) begin
    if (srst) begin
      state_q <= START;
    end else if (at_term) begin
      state_q <= START;
    end else begin
      state_q <= state_step;
    end
  end

  initial begin
    AST_START_LEGAL: assert (START != '1); // R2
  end

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (srst)
    !(&state_q)); // R2
  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> (state_q == START)); // R4
  AST_RELOAD_AT_TERM: assert property (@(posedge clk) disable iff (srst)
    at_term |=> (state_q == START)); // R6
  AST_ALWAYS_MOVES: assert property (@(posedge clk) disable iff (srst)
    (!at_term && !$past(srst)) |=> (state_q != $past(state_q))); // R1

endmodule

// File: rtl/lfsr_div_toggle.sv
module lfsr_div_toggle #(
  parameter int HALF = 12500
) (
  input  logic clk,
  input  logic srst,
  input  logic flip,
  output logic out
);

  localparam int CW = $clog2(HALF + 1);

  logic          out_q;
  logic [CW-1:0] span_q;   // cycles since last flip, used by the checks only

  always_ff @(posedge clk) begin
    if (srst) begin
      out_q <= 1'b0;
    end else if (flip) begin
      out_q <= ~out_q;
    end
  end

  always_ff @(posedge clk) begin
    if (srst || flip) begin
      span_q <= '0;
    end else if (span_q != CW'(HALF)) begin
      span_q <= span_q + 1'b1;
    end
  end

  assign out = out_q;

  AST_FLIP_ON_TERM: assert property (@(posedge clk) disable iff (srst)
    flip |=> (out_q != $past(out_q))); // R6
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (srst)
    (!flip && !$past(srst)) |=> $stable(out_q)); // R7
  AST_HALF_SPAN: assert property (@(posedge clk) disable iff (srst)
    flip |-> (span_q == CW'(HALF - 1))); // R7
  AST_NO_LATE_FLIP: assert property (@(posedge clk) disable iff (srst)
    span_q < CW'(HALF)); // R7
  AST_OUT_CLEARED: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> !out_q); // R5

endmodule

// File: rtl/lfsr_clk_div.sv
module lfsr_clk_div #(
  parameter int           W           = 14,
  parameter logic [W-1:0] TAPS        = 14'h2015,
  parameter int           HALF_PERIOD = 12500,
  parameter logic [W-1:0] START_STATE = '0,
  parameter logic [W-1:0] TERM_STATE  = W'(lfsr_div_pkg::lfsr_advance(
                            32'(START_STATE), 32'(TAPS), W, HALF_PERIOD - 1))
) (
  input  logic clk_in,
  input  logic srst,
  output logic clk_div_out
);

  logic at_term;

  lfsr_div_core #(
    .W     (W),
    .TAPS  (TAPS),
    .START (START_STATE),
    .TERM  (TERM_STATE)
  ) core_i (
    .clk     (clk_in),
    .srst    (srst),
    .at_term (at_term)
  );

  lfsr_div_toggle #(
    .HALF (HALF_PERIOD)
  ) tog_i (
    .clk  (clk_in),
    .srst (srst),
    .flip (at_term),
    .out  (clk_div_out)
  );

  initial begin
    AST_TERM_NOT_START: assert (TERM_STATE != START_STATE); // R3
  end

endmodule

// File: tb/lfsr_clk_div_tb_top.sv
`timescale 1ns/1ps
module lfsr_clk_div_tb_top;

  // Bench model of one step: taps at bits 13, 4, 2, 0, inverted parity.
  function automatic logic [13:0] tb_step(input logic [13:0] s);
    return {s[12:0], ~(s[13] ^ s[4] ^ s[2] ^ s[0])};
  endfunction

  function automatic logic [13:0] tb_adv(input logic [13:0] s, input int n);
    logic [13:0] v;
    v = s;
    for (int i = 0; i < n; i++) v = tb_step(v);
    return v;
  endfunction

  localparam int          MAIN_HALF  = 12500;
  localparam int          SMALL_HALF = 41;
  localparam logic [13:0] S_START    = 14'h0155;
  localparam logic [13:0] S_TERM     = tb_adv(S_START, SMALL_HALF - 1);

  logic clk = 1'b0;
  logic srst_m = 1'b1;
  logic srst_s = 1'b1;
  logic o_m;
  logic o_s;
  int   checks = 0;
  int   errors = 0;

  always #2.5 clk = ~clk;

  lfsr_clk_div dut_i (
    .clk_in (clk), .srst (srst_m), .clk_div_out (o_m)
  );

  lfsr_clk_div #(
    .HALF_PERIOD (SMALL_HALF),
    .START_STATE (S_START),
    .TERM_STATE  (S_TERM)
  ) dut_s (
    .clk_in (clk), .srst (srst_s), .clk_div_out (o_s)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic cur(input int sel);
    return (sel == 0) ? o_m : o_s;
  endfunction

  // Counts falling clock edges until the output shows lvl.
  task automatic wait_level(input int sel, input logic lvl, input int limit,
                            output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cur(sel) != lvl && n < limit);
  endtask

  initial begin
    int n;
    int r;
    logic [13:0] v;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    chk("R5 main low in reset", int'(o_m), 0);
    chk("R5 small low in reset", int'(o_s), 0);

    // R1: the bench model itself has the full sequence length
    v = 14'h0000; n = 0;
    do begin v = tb_step(v); n++; end while (v != 14'h0000 && n < 20000);
    chk("R1 model sequence length", n, 16383);

    // Main instance: default ratio
    srst_m = 1'b0;
    @(negedge clk);
    chk("R5 main low after release", int'(o_m), 0);
    wait_level(0, 1'b1, 3 * MAIN_HALF, n);
    chk("R8 R3 main first rise", n + 1, MAIN_HALF);
    wait_level(0, 1'b0, 3 * MAIN_HALF, n);
    chk("R7 main high span", n, MAIN_HALF);
    wait_level(0, 1'b1, 3 * MAIN_HALF, n);
    chk("R7 main low span", n, MAIN_HALF);
    // R9: reset while output high
    r = $urandom_range(12000, 100);
    repeat (r) @(negedge clk);
    chk("R9 main still high before reset", int'(o_m), 1);
    srst_m = 1'b1;
    @(negedge clk);
    chk("R9 main cleared by reset", int'(o_m), 0);
    repeat (2) @(negedge clk);
    srst_m = 1'b0;
    wait_level(0, 1'b1, 3 * MAIN_HALF, n);
    chk("R9 main rise after mid reset", n, MAIN_HALF);
    srst_m = 1'b1;

    // Short instance: terminal from the bench model checks the taps (R1)
    srst_s = 1'b0;
    wait_level(1, 1'b1, 3 * SMALL_HALF, n);
    chk("R1 R8 small first rise", n, SMALL_HALF);
    wait_level(1, 1'b0, 3 * SMALL_HALF, n);
    chk("R7 small high span", n, SMALL_HALF);
    wait_level(1, 1'b1, 3 * SMALL_HALF, n);
    chk("R7 small low span", n, SMALL_HALF);

    // Directed: reset lands on the terminal cycle
    srst_s = 1'b1;
    @(negedge clk);
    srst_s = 1'b0;
    repeat (SMALL_HALF - 1) @(negedge clk);
    chk("R5 small low before terminal", int'(o_s), 0);
    srst_s = 1'b1;
    @(negedge clk);
    chk("R5 R4 no flip when reset hits terminal", int'(o_s), 0);
    srst_s = 1'b0;
    wait_level(1, 1'b1, 3 * SMALL_HALF, n);
    chk("R4 small rise after terminal reset", n, SMALL_HALF);

    // Random reset instants
    for (int k = 0; k < 30; k++) begin
      r = $urandom_range(200, 0);
      repeat (r) @(negedge clk);
      srst_s = 1'b1;
      r = $urandom_range(3, 1);
      repeat (r) @(negedge clk);
      chk("R5 small cleared by random reset", int'(o_s), 0);
      srst_s = 1'b0;
      wait_level(1, 1'b1, 3 * SMALL_HALF, n);
      chk("R9 R4 small rise after random reset", n, SMALL_HALF);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule